// File: doc/BRIEF.md
# Sinusoidal PWM Reference Generator

This block computes the modulating reference for a center-aligned PWM channel. The channel's counter only counts up, from -TOP to TOP-1. Once per carrier period the PWM timer pulses a sample strobe. On each strobe the block takes one step along a 400-point fundamental sine. While a timed third-harmonic term is enabled, it adds that term. It then scales the sum to a half pulse width (HPW) and presents the compare pair -HPW / +HPW to the channel. The output stage sets its pin at -HPW and clears it at +HPW, so the duty cycle is HPW/TOP.

At a 20 kHz carrier, 400 samples per cycle give a 50 Hz fundamental. An internal timer requests that the third-harmonic term be switched in or out every TOGGLE_SAMPLES strobes (default 100000, i.e. 5 s at 20 kHz). A request is honoured only when the fundamental index returns to zero, so the reference never jumps. An optional clamp keeps the duty cycle between 10 % and 90 %. A load pulse one clock after each strobe tells the PWM channel when to take the new pair.

Top module: `spwm_ref_gen`

## Requirements
- R1: While reset is held, and after it until the first strobe, load_en is 0 and both compare outputs are 0.
- R2: load_en is 1 in exactly the clock cycle that follows a cycle with smp_stb high, and 0 otherwise. cmp_pos and cmp_neg change only at clock edges where smp_stb is sampled high.
- R3: At every load, cmp_neg equals the two's complement negation of cmp_pos.
- R4: Let H = floor(TOP/2) and let s be the reference in [-1, 1]. Then HPW = H + s*(H-1), computed from a quarter-wave sine table in Q14. Before clamping, the result is within 2 counts of the exact real value.
- R5: The k-th strobe after reset (k from 0) uses the fundamental angle 2*pi*(k mod 400)/400. Strobes 0 and 200 give HPW = floor(TOP/2) exactly.
- R6: The harmonic term is off after reset. A timer counts strobes and requests a toggle every TOGGLE_SAMPLES strobes. The request is applied at the next strobe whose fundamental index is 0, and the new state affects samples from the strobe after that one.
- R7: While the harmonic term is on, s = sin(a) + sin(3a)/6, where a is the fundamental angle. The harmonic index stays equal to 3x the fundamental index mod 400.
- R8: With CLAMP_EN = 1 (default), HPW satisfies 10*HPW >= TOP and 10*HPW <= 9*TOP. At TOP = 500, strobes 100 and 300 give 450 and 50.
- R9: With CLAMP_EN = 0, HPW is limited only to 1..TOP-1. At TOP = 500, strobes 100 and 300 give 499 and 1, and TOP = 2 always gives 1.
- R10: top is sampled at each strobe, so a new TOP value shapes the very next compare pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle pulse per carrier period from the PWM timer |
| top | input | DW | Half count range TOP (2 to 2^(DW-1)-1) |
| cmp_neg | output | DW | Signed compare value -HPW (output set point) |
| cmp_pos | output | DW | Signed compare value +HPW (output clear point) |
| load_en | output | 1 | One-cycle pulse: the compare pair is new and stable |

## Verification
The embedded properties watch, on every cycle, the timing of the load pulse relative to the strobe and the holding of the pair between strobes. They also check the symmetry of the pair, that HPW stays in range and inside the duty clamp for the sampled TOP, the 3:1 lock between the two phase indices, and that a harmonic toggle lands only on a zero index of the fundamental. The bench's scenarios show what those properties cannot: the actual sine values against a real-valued model, exact peak and midpoint values, and how long a pending toggle waits for the zero crossing. They also show the audible change the harmonic makes, and the effect of altering TOP between samples, down to the degenerate TOP = 2.

// File: rtl/spwm_ref_gen.sv
module spwm_ref_gen #(
  parameter int DW             = 16,
  parameter int QTR            = 100,
  parameter int TOGGLE_SAMPLES = 100000,
  parameter bit CLAMP_EN       = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_stb,
  input  logic [DW-1:0]        top,
  output logic signed [DW-1:0] cmp_neg,
  output logic signed [DW-1:0] cmp_pos,
  output logic                 load_en
);
  localparam int PER = 4 * QTR;
  localparam int PHW = $clog2(PER);
  localparam int IW  = $clog2(QTR + 1);
  localparam int TCW = $clog2(TOGGLE_SAMPLES + 1);
  localparam int SW  = 15;
  localparam int AW  = DW + 22;
  localparam logic [PHW-1:0] PH_LAST = PHW'(PER - 1);
  localparam logic [TCW-1:0] T_LAST  = TCW'(TOGGLE_SAMPLES - 1);
  localparam logic signed [AW-1:0] ONE  = 1;
  localparam logic signed [AW-1:0] NINE = 9;
  localparam logic signed [AW-1:0] TEN  = 10;
  localparam logic signed [AW-1:0] K6   = 10923;

  function automatic logic [SW-1:0] sine_point(input int k);
    longint x, t, acc;
    x = (64'sd1686629713 * longint'(k)) / longint'(QTR);
    t = x;
    acc = x;
    for (int n = 1; n <= 6; n++) begin
      t = (t * x) >>> 30;
      t = (t * x) >>> 30;
      t = -t / longint'((2 * n) * (2 * n + 1));
      acc = acc + t;
    end
    acc = (acc + 64'sd32768) >>> 16;
    if (acc > 64'sd16384) acc = 64'sd16384;
    if (acc < 64'sd0) acc = 64'sd0;
    return SW'(acc);
  endfunction

  function automatic logic [IW:0] fold(input logic [PHW-1:0] p);
    int q;
    q = int'(p);
    if (q < QTR)          return {1'b0, IW'(q)};
    else if (q < 2 * QTR) return {1'b0, IW'(2 * QTR - q)};
    else if (q < 3 * QTR) return {1'b1, IW'(q - 2 * QTR)};
    else                  return {1'b1, IW'(4 * QTR - q)};
  endfunction

  logic [SW-1:0] qtab [0:QTR];
  for (genvar g = 0; g <= QTR; g++) begin : g_tab
    assign qtab[g] = sine_point(g);
  end

  logic [PHW-1:0] ph_f, ph_h;
  logic [TCW-1:0] tcnt;
  logic           pend, harm_en;
  logic [IW:0]    ff, fh;
  logic signed [AW-1:0] fund, harm, harm6, smp, top_w, half, amp;
  logic signed [AW-1:0] scaled, hpw_raw, lo, hi, lim, hpw;

  assign ff      = fold(ph_f);
  assign fh      = fold(ph_h);
  assign fund    = ff[IW] ? -AW'(qtab[ff[IW-1:0]]) : AW'(qtab[ff[IW-1:0]]);
  assign harm    = fh[IW] ? -AW'(qtab[fh[IW-1:0]]) : AW'(qtab[fh[IW-1:0]]);
  assign harm6   = (harm * K6) >>> 16;
  assign smp     = fund + (harm_en ? harm6 : '0);
  assign top_w   = AW'(top);
  assign half    = top_w >>> 1;
  assign amp     = half - ONE;
  assign scaled  = (smp * amp) >>> 14;
  assign hpw_raw = half + scaled;
  assign lo      = (top_w + NINE) / TEN;
  assign hi      = (top_w * NINE) / TEN;

  always_comb begin
    lim = hpw_raw;
    if (lim < ONE) lim = ONE;
    if (lim > top_w - ONE) lim = top_w - ONE;
    hpw = lim;
    if (CLAMP_EN) begin
      if (hpw < lo) hpw = lo;
      if (hpw > hi) hpw = hi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_f    <= '0;
      ph_h    <= '0;
      tcnt    <= '0;
      pend    <= 1'b0;
      harm_en <= 1'b0;
      cmp_pos <= '0;
      cmp_neg <= '0;
      load_en <= 1'b0;
    end else begin
      load_en <= smp_stb;
      if (smp_stb) begin
        cmp_pos <= DW'(hpw);
        cmp_neg <= DW'(-hpw);
        ph_f    <= (ph_f == PH_LAST) ? '0 : ph_f + PHW'(1);
        ph_h    <= (int'(ph_h) >= PER - 3) ? PHW'(int'(ph_h) + 3 - PER) : ph_h + PHW'(3);
        if (pend && ph_f == '0) begin
          harm_en <= ~harm_en;
          pend    <= 1'b0;
        end
        if (tcnt == T_LAST) begin
          tcnt <= '0;
          pend <= 1'b1;
        end else begin
          tcnt <= tcnt + TCW'(1);
        end
      end
    end
  end

  // R2
  load_follow_chk: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> load_en);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> (!load_en && $stable(cmp_pos) && $stable(cmp_neg)));

  // R3
  pair_sym_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |-> (cmp_neg == -cmp_pos));

  // R9
  hpw_range_chk: assert property (@(posedge clk) disable iff (rst)
    (load_en && int'($past(top)) >= 2) |->
      (int'(cmp_pos) >= 1 && int'(cmp_pos) < int'($past(top))));

  // R7
  phase_lock_chk: assert property (@(posedge clk) disable iff (rst)
    int'(ph_h) == (3 * int'(ph_f)) % PER);

  // R6
  flip_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (harm_en != $past(harm_en)) |-> ($past(smp_stb) && $past(ph_f) == '0));

  if (CLAMP_EN) begin : g_clamp_chk
    // R8
    duty_window_chk: assert property (@(posedge clk) disable iff (rst)
      (load_en && int'($past(top)) >= 2) |->
        (10 * int'(cmp_pos) >= int'($past(top)) && 10 * int'(cmp_pos) <= 9 * int'($past(top))));
  end
endmodule

// File: tb/spwm_ref_gen_bench.sv
`timescale 1ns/1ps
module spwm_ref_gen_bench;
  localparam int DW   = 16;
  localparam int TOG  = 1000;
  localparam int NSEG = 6;
  localparam int SEG_TOP [NSEG] = '{500, 1000, 2, 37, 500, 20000};
  localparam int SEG_LEN [NSEG] = '{1300, 800, 50, 400, 900, 100};
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0;
  logic [DW-1:0] top = 16'd500;
  logic signed [DW-1:0] neg_c, pos_c, neg_r, pos_r;
  logic ld_c, ld_r;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spwm_ref_gen #(.DW(DW), .QTR(100), .TOGGLE_SAMPLES(TOG), .CLAMP_EN(1'b1)) u_spwm_ref_gen (
    .clk(clk), .rst(rst), .smp_stb(stb), .top(top),
    .cmp_neg(neg_c), .cmp_pos(pos_c), .load_en(ld_c));

  spwm_ref_gen #(.DW(DW), .QTR(100), .TOGGLE_SAMPLES(TOG), .CLAMP_EN(1'b0)) u_spwm_ref_gen_raw (
    .clk(clk), .rst(rst), .smp_stb(stb), .top(top),
    .cmp_neg(neg_r), .cmp_pos(pos_r), .load_en(ld_r));

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic real ref_hpw(input int n, input bit en, input int t, input bit clamp);
    real s, half, r;
    s = $sin(TWO_PI * real'(n % 400) / 400.0);
    if (en) s = s + $sin(TWO_PI * real'((3 * n) % 400) / 400.0) / 6.0;
    half = real'(t / 2);
    r = half + s * (half - 1.0);
    if (r < 1.0) r = 1.0;
    if (r > real'(t - 1)) r = real'(t - 1);
    if (clamp) begin
      if (r < real'((t + 9) / 10)) r = real'((t + 9) / 10);
      if (r > real'((9 * t) / 10)) r = real'((9 * t) / 10);
    end
    return r;
  endfunction

  function automatic bit near(input int act, input real r);
    real d;
    d = real'(act) - r;
    if (d < 0.0) d = -d;
    return d <= 2.0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2: watchdog expired, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n = 0;
    int tcnt_m = 0;
    bit pend_m = 1'b0;
    bit en_m = 1'b0;
    repeat (5) @(negedge clk);
    // R1: state during reset
    chk(!ld_c && !ld_r, "R1 load during reset", int'(ld_c), 0);
    chk(pos_c == 0 && neg_c == 0, "R1 clamped pair during reset", int'(pos_c), 0);
    chk(pos_r == 0 && neg_r == 0, "R1 raw pair during reset", int'(pos_r), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1: idle after reset
    chk(!ld_c && !ld_r && pos_c == 0 && pos_r == 0, "R1 idle after reset", int'(pos_c), 0);

    for (int s = 0; s < NSEG; s++) begin
      for (int i = 0; i < SEG_LEN[s]; i++) begin
        real ec, er;
        int  hc, hr;
        string tag;
        top = DW'(SEG_TOP[s]);
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        ec = ref_hpw(n, en_m, SEG_TOP[s], 1'b1);
        er = ref_hpw(n, en_m, SEG_TOP[s], 1'b0);
        hc = int'(pos_c);
        hr = int'(pos_r);
        if (n >= TOG && n <= 1200) tag = "R6 pending toggle waits for zero index";
        else if (i == 0 && s > 0) tag = "R10 new TOP on next pair";
        else if (en_m) tag = "R7 harmonic-on sample";
        else tag = "R4 R5 fundamental sample";
        chk(ld_c && ld_r, "R2 load pulse after strobe", int'(ld_c), 1);
        chk(near(hc, ec), $sformatf("%s R8 n=%0d", tag, n), hc, $rtoi(ec));
        chk(near(hr, er), $sformatf("%s R9 n=%0d", tag, n), hr, $rtoi(er));
        chk(int'(neg_c) == -hc && int'(neg_r) == -hr, "R3 symmetric pair", int'(neg_c), -hc);
        if (s == 0 && (n == 0 || n == 200)) begin
          chk(hc == 250 && hr == 250, "R5 midpoint exact", hr, 250);
        end
        if (s == 0 && n == 100) begin
          chk(hr == 499, "R9 raw positive peak", hr, 499);
          chk(hc == 450, "R8 clamped positive peak", hc, 450);
        end
        if (s == 0 && n == 300) begin
          chk(hr == 1, "R9 raw negative peak", hr, 1);
          chk(hc == 50, "R8 clamped negative peak", hc, 50);
        end
        if (SEG_TOP[s] == 2) begin
          chk(hr == 1 && hc == 1, "R9 TOP=2 degenerate", hr, 1);
        end
        @(negedge clk);
        chk(!ld_c && !ld_r, "R2 load pulse one cycle", int'(ld_c), 0);
        chk(int'(pos_c) == hc && int'(pos_r) == hr, "R2 pair held between strobes", int'(pos_r), hr);
        if (pend_m && (n % 400) == 0) begin
          en_m = ~en_m;
          pend_m = 1'b0;
        end
        if (tcnt_m == TOG - 1) begin
          tcnt_m = 0;
          pend_m = 1'b1;
        end else begin
          tcnt_m++;
        end
        n++;
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule